// File: doc/BRIEF.md
# PHY Status-Change Interrupt Register

This block is one 16-bit management register of a 10/100 Ethernet transceiver. It watches three live status levels from the line side: link up, 100 Mb/s speed and full duplex. It records every toggle of each level in a sticky change flag. The block combines these flags with a mask bit for each source and with one master mask. From that it produces an interrupt status bit and an active-low interrupt pin.

The register is reached through a plain strobe interface, and the serial management frame logic sits outside this block.
- `rd_data` always shows the current register contents.
- A one-cycle pulse on `rd_en` marks that the word was consumed. At the end of that cycle the change flags and the status bit clear.
- A pulse on `wr_en` loads the mask bits from `wr_data`.

There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Every strobe takes effect in the cycle it is asserted.

Top module: `phy_evt_irq`

## Requirements
- R1: After reset, the link mask (bit 12), duplex mask (bit 11), speed mask (bit 10) and master mask (bit 8) are all 1. Every change flag is 0, `rd_data` is 16'h1D00 and `irq_n` is 1.
- R2: A toggle in either direction of `link_up`, `speed_100` or `full_dplx` sets bit 2, bit 3 or bit 4 respectively. The flag stays set until a read. The levels present when reset is released never set a flag.
- R3: During the cycle with `rd_en` high, `rd_data` shows the value from before the clear. After that clock edge, bits 4, 3, 2 and 0 read 0 unless a new change arrived.
- R4: A change that is detected in the same cycle as a read stays latched. The read itself returns the old flag value.
- R5: A write changes only bits 12, 11, 10 and 8 of the register. Values written to every other bit position have no effect.
- R6: Bit 0 reads 1 exactly when the master mask is 0 and some change flag is set while its own mask is 0. `irq_n` is always the inverse of bit 0.
- R7: While the master mask is 1, bit 0 reads 0 and `irq_n` stays 1, whatever the flags and source masks hold.
- R8: A source mask blocks only the interrupt path. The flag of a masked source still latches. If the mask is cleared before a read, that pending flag raises the interrupt.
- R9: Bits 15:13, 9, 7:5 and 1 always read 0.
- R10: Each status input passes through a two-flop synchronizer and then an edge stage. A flag is not visible two clock edges after the input changes, and is visible after the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, loads the mask bits from `wr_data` |
| wr_data | input | 16 | Write data word |
| rd_en | input | 1 | Read strobe, clears the change flags at the end of the cycle |
| rd_data | output | 16 | Current register contents |
| link_up | input | 1 | Live link status (asynchronous) |
| speed_100 | input | 1 | Live speed status, 1 = 100 Mb/s (asynchronous) |
| full_dplx | input | 1 | Live duplex status, 1 = full (asynchronous) |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The hardest case to bring about is a status change that is detected in exactly the same cycle as a read. The detection happens three register stages behind the input pin, so `rd_en` must be raised on the precise cycle in which the synchronized edge emerges.

The stimulus toggles a status input just after one clock edge. It then lets two further edges pass and raises `rd_en` for the following cycle. The scoreboard expects that read to return the flag clear and the next read to return it set. A second difficult case is a flag that latched while its source was masked; the bench reaches it by writing the mask clear afterwards and watching `irq_n` fall without any new event.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;

  localparam int REG_W = 16;
  localparam int NSRC  = 3;

  // source index order used on every internal vector
  localparam int SRC_LINK  = 0;
  localparam int SRC_SPEED = 1;
  localparam int SRC_DPLX  = 2;

  // register bit positions, indexed by source
  localparam int FLAG_POS [NSRC] = '{2, 3, 4};
  localparam int MASK_POS [NSRC] = '{12, 10, 11};
  localparam int MASTER_POS = 8;
  localparam int IRQ_POS    = 0;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [REG_W-1:0] reg_word_t;

  // value of the register right after reset
  function automatic reg_word_t reset_word();
    reg_word_t w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[MASK_POS[i]] = 1'b1;
    w[MASTER_POS] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/phy_evt_sync.sv
module phy_evt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_out = stg_q[LAST];

endmodule

// File: rtl/phy_evt_detect.sv
module phy_evt_detect #(
  parameter int W     = 3,
  parameter int PRIME = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] toggled
);

  // prime_q fills with ones so that edges are only reported once prev_q
  // holds a genuine synchronized sample rather than the reset value
  logic [PRIME-1:0] prime_q;
  logic [W-1:0]     prev_q;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= '0;
      prev_q  <= '0;
    end else begin
      prime_q <= {prime_q[PRIME-2:0], 1'b1};
      prev_q  <= level;
    end
  end

  assign armed = prime_q[PRIME-1];

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign toggled[i] = armed & (level[i] ^ prev_q[i]);
  end

endmodule

// File: rtl/phy_evt_flags.sv
module phy_evt_flags #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic         clr,
  output logic [W-1:0] flag
);

  for (genvar i = 0; i < W; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr) | set_ev[i];
    end
    assign flag[i] = flag_q;
  end

endmodule

// File: rtl/phy_evt_irq.sv
module phy_evt_irq
  import phy_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             link_up,
  input  logic             speed_100,
  input  logic             full_dplx,
  output logic             irq_n
);

  localparam int PRIME = SYNC_STAGES + 1;

  src_vec_t raw_lvl, sync_lvl, ev_w, flag_q, src_mask_q, pend;
  logic     master_q, irq_act;
  logic     unused_wr;

  assign raw_lvl[SRC_LINK]  = link_up;
  assign raw_lvl[SRC_SPEED] = speed_100;
  assign raw_lvl[SRC_DPLX]  = full_dplx;

  phy_evt_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_lvl), .sync_out(sync_lvl)
  );

  phy_evt_detect #(.W(NSRC), .PRIME(PRIME)) u_det (
    .clk(clk), .rst_n(rst_n), .level(sync_lvl), .toggled(ev_w)
  );

  phy_evt_flags #(.W(NSRC)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_w), .clr(rd_en), .flag(flag_q)
  );

  // mask bits: the only writable state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mask_q <= '1;
      master_q   <= 1'b1;
    end else if (wr_en) begin
      for (int i = 0; i < NSRC; i++) src_mask_q[i] <= wr_data[MASK_POS[i]];
      master_q <= wr_data[MASTER_POS];
    end
  end

  assign unused_wr = ^wr_data;

  assign pend    = flag_q & ~src_mask_q;
  assign irq_act = ~master_q & (|pend);
  assign irq_n   = ~irq_act;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      rd_data[FLAG_POS[i]] = flag_q[i];
      rd_data[MASK_POS[i]] = src_mask_q[i];
    end
    rd_data[MASTER_POS] = master_q;
    rd_data[IRQ_POS]    = irq_act;
  end

endmodule

// File: rtl/phy_evt_irq_chk.sv
module phy_evt_irq_chk
  import phy_evt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             rd_en,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_n,
  input logic [NSRC-1:0]  ev,
  input logic [NSRC-1:0]  flg
);

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:13] == 3'b0 && rd_data[9] == 1'b0 && rd_data[7:5] == 3'b0 && rd_data[1] == 1'b0);

  // R6
  pin_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~rd_data[0]);

  // R7
  master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[8] |-> irq_n);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[12] == $past(wr_data[12]) && rd_data[11] == $past(wr_data[11]) &&
               rd_data[10] == $past(wr_data[10]) && rd_data[8] == $past(wr_data[8])));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rd_data[12:10]) && $stable(rd_data[8])));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && (|flg)) |=> ((flg & $past(flg)) == $past(flg)));

  // R4
  event_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flg & $past(ev)) == $past(ev)));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ev == '0) |=> (flg == '0 && rd_data[0] == 1'b0));

endmodule

bind phy_evt_irq phy_evt_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n),
  .ev(ev_w), .flg(flag_q)
);

// File: tb/test_phy_evt_irq.sv
module test_phy_evt_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        link_up = 1'b0;
  logic        speed_100 = 1'b0;
  logic        full_dplx = 1'b0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  phy_evt_irq i_phy_evt_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .link_up(link_up),
    .speed_100(speed_100), .full_dplx(full_dplx), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each read word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected read, got %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic do_read(input string tag, input logic [15:0] exp);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] v);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic peek(input string tag, input logic [15:0] exp, input logic exp_irq_n);
    @(negedge clk);
    check(tag, rd_data, exp);
    check(tag, {15'b0, irq_n}, {15'b0, exp_irq_n});
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    link_up = 1'b1;  // level present at reset release must not flag
    idle(3);
    rst_n = 1'b1;
    idle(8);
    // R1 R9 R2: reset word, no flag for initial levels
    peek("R1", 16'h1D00, 1'b1);

    // R2 R7: link toggle latches but masks keep pin high
    @(posedge clk); #1; link_up = 1'b0;
    idle(5);
    peek("R7", 16'h1D04, 1'b1);
    do_read("R2", 16'h1D04);
    do_read("R3", 16'h1D00);

    // R10: synchronizer latency
    @(posedge clk); #1; speed_100 = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R10 early", rd_data, 16'h1D00);
    @(posedge clk);
    @(negedge clk); check("R10 late", rd_data, 16'h1D08);
    do_read("R10", 16'h1D08);

    // R5 R9: write with every non-mask bit set, masks cleared
    do_write(16'hE2FF);
    peek("R5", 16'h0000, 1'b1);
    do_write(16'hFFFF);
    peek("R5", 16'h1D00, 1'b1);

    // R8: link masked, others open, master open
    do_write(16'h1000);
    @(posedge clk); #1; link_up = 1'b1;
    idle(5);
    peek("R8 masked", 16'h1004, 1'b1);
    do_write(16'h0000);
    peek("R8 unmask", 16'h0005, 1'b0);
    do_read("R8", 16'h0005);
    peek("R3", 16'h0000, 1'b1);

    // R6: duplex change with all masks open
    @(posedge clk); #1; full_dplx = 1'b1;
    idle(5);
    peek("R6", 16'h0011, 1'b0);
    // R7: master mask set with pending flag
    do_write(16'h0100);
    peek("R7", 16'h0110, 1'b1);
    do_write(16'h0000);
    peek("R6", 16'h0011, 1'b0);
    do_read("R6", 16'h0011);

    // R4: read on the cycle the edge is detected
    @(posedge clk); #1; speed_100 = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    exp_q.push_back(16'h0000); tag_q.push_back("R4 same-cycle");
    rd_en = 1'b1;
    @(posedge clk); #1; rd_en = 1'b0;
    do_read("R4 kept", 16'h0009);

    // R2: two toggles before a read still leave one sticky flag
    @(posedge clk); #1; link_up = 1'b0;
    idle(5);
    @(posedge clk); #1; link_up = 1'b1;
    idle(5);
    do_read("R2", 16'h0005);
    peek("R3", 16'h0000, 1'b1);

    idle(2);
    check("R3 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule